// File: doc/BRIEF.md
# Cascaded Search Winner Arbiter

This block sits in every device of a depth-cascaded search table. Each device compares a key against its own entries and reports a local hit with a match address. Up to 31 devices form one table. They are grouped into up to four blocks of up to eight devices. Device priority falls with position inside a block, and block priority falls with block number. The arbiter in each device trades hit flags with its peers and decides whether its device is the single global winner. Only the global winner may drive the shared result-address bus and its strobes.

Devices exchange two registered flags. The first is a local-hit flag between members of the same block. The second is a block-hit flag, taken from the last member of each block and sent to every downstream block. When no device hits, one device, configured as the default bus owner, drives the idle pattern. A static table-size setting delays the bus hand-off by a number of cycles that grows with the size of the cascade. A small decoder also compares a command's 5-bit target ID with the device ID to select the device for register access.

Top module: `cascade_winner_arbiter`

## Requirements
- R1: `lhit_out` rises in the cycle after a clock edge that samples `search_vld` and `local_hit` both high, and is low after an edge that samples `search_vld` low, whatever the value of `local_hit`.
- R2: Two edges after the search, `bhit_out` is the OR of this device's hit and all in-block hit inputs. A device is the local winner only if it hit and every in-block input from a higher-priority position is low.
- R3: The global winner is the local winner whose block-hit inputs are all low. Across the cascade, this is the hitting device with the lowest index, where index = block * 8 + position.
- R4: In every cycle, including during reset, exactly one device in a correctly configured cascade has `drive_en` high.
- R5: The winner drives its match address with `bus_ce_n` and `bus_ale_n` low and `bus_we_n` high. This happens in the cycle that follows edge 2+L after the sampling edge, where L is the hand-off latency.
- R6: When no device hits, or no search was issued, the device with `is_last` high drives `bus_addr` as all ones (22 bits) with all three strobes high.
- R7: `tbl_size` sets L: value 0 gives L=0, value 1 gives L=1, and values 2 and 3 give L=2.
- R8: With `tbl_size`=0, both hit-input buses are ignored. With `tbl_size`=1, only the block-hit inputs are ignored.
- R9: `win_status` sets on the clock edge that resolves a global win for this device, and stays set until reset. A hit that loses arbitration does not set it.
- R10: `reg_sel` is high only while `cmd_vld` is high. It also needs `cmd_id` to equal `dev_id`, or `cmd_id` to be 31 on the device with `is_last` high.
- R11: Under reset, `lhit_out`, `bhit_out` and `win_status` are low. Only the `is_last` device drives, and it drives the idle pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| search_vld | input | 1 | A search is issued this cycle |
| local_hit | input | 1 | This device's compare array matched |
| hit_addr | input | 22 | Result address for this device's match |
| lhit_in | input | DEVS_PER_BLK-1 | Local-hit flags from higher-priority devices in the block; bit j is position j |
| bhit_in | input | NUM_BLKS-1 | Block-hit flags from upstream blocks; bit k is block k |
| tbl_size | input | 2 | Static cascade size, which selects the hand-off latency |
| is_last | input | 1 | Marks the default bus owner (last device of the last block) |
| dev_id | input | 5 | Device ID |
| cmd_vld | input | 1 | A register command is present |
| cmd_id | input | 5 | Target ID of the command |
| lhit_out | output | 1 | Registered local-hit flag to the block's downstream devices |
| bhit_out | output | 1 | Registered block-hit flag to downstream blocks |
| win_status | output | 1 | Sticky global-winner status bit |
| reg_sel | output | 1 | Device is selected for register access |
| drive_en | output | 1 | Device owns the shared result bus this cycle |
| bus_addr | output | 22 | Result address value |
| bus_ce_n | output | 1 | Chip-enable strobe, active low |
| bus_we_n | output | 1 | Write-enable strobe, active low |
| bus_ale_n | output | 1 | Address-latch strobe, active low |

## Verification
The bench builds a full 31-device cascade of four blocks, the last block holding seven devices. It feeds the cascade sparse random hit vectors, together with directed patterns. The directed patterns are:
- every device hitting, which separates in-block priority from block priority;
- a lone hit on the default owner, which separates a real win from the idle pattern;
- hits only at the last position of upper blocks, which exercises the block hand-off;
- hits with no search issued, which must be ignored.

A separate single device is driven with forced-high hit-input buses under each table-size setting. This shows both which inputs each setting ignores and the exact edge on which the bus is taken. Random command IDs, including the all-ones ID, tell an ID match apart from the default-owner select.

// File: rtl/cascade_arb_pkg.sv
package cascade_arb_pkg;

    localparam int SRAM_AW   = 22;
    localparam int ID_W      = 5;
    localparam int LAT_STEPS = 3;

    typedef struct packed {
        logic               win;
        logic               any_hit;
        logic [SRAM_AW-1:0] addr;
    } drive_slot_t;

    // in-block hit inputs count for every size above a single device
    function automatic logic local_on(input logic [1:0] tsz);
        return tsz != 2'b00;
    endfunction

    // block-hit inputs count only for multi-block cascades
    function automatic logic block_on(input logic [1:0] tsz);
        return tsz[1];
    endfunction

endpackage

// File: rtl/arb_hit_stage.sv
module arb_hit_stage
    import cascade_arb_pkg::*;
#(
    parameter int LOC_W = 7,
    parameter int BLK_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               search_vld,
    input  logic               local_hit,
    input  logic [SRAM_AW-1:0] hit_addr,
    input  logic [LOC_W-1:0]   lhit_in,
    input  logic [BLK_W-1:0]   bhit_in,
    input  logic [1:0]         tbl_size,
    output logic               lhit_q_o,
    output logic               bhit_q_o,
    output drive_slot_t        slot_o
);

    logic               hit_q;
    logic               lwin_q;
    logic               bhit_q;
    logic [SRAM_AW-1:0] addr_s1;
    logic [SRAM_AW-1:0] addr_s2;
    logic               up_local;
    logic               up_block;

    assign up_local = local_on(tbl_size) & (|lhit_in);
    assign up_block = block_on(tbl_size) & (|bhit_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            lwin_q  <= 1'b0;
            bhit_q  <= 1'b0;
            addr_s1 <= '0;
            addr_s2 <= '0;
        end else begin
            hit_q   <= search_vld & local_hit;
            addr_s1 <= hit_addr;
            lwin_q  <= hit_q & ~up_local;
            bhit_q  <= hit_q | up_local;
            addr_s2 <= addr_s1;
        end
    end

    assign lhit_q_o       = hit_q;
    assign bhit_q_o       = bhit_q;
    assign slot_o.win     = lwin_q & ~up_block;
    assign slot_o.any_hit = bhit_q | up_block;
    assign slot_o.addr    = addr_s2;

    // R2
    lwin_src_chk: assert property (@(posedge clk) disable iff (rst)
        lwin_q |-> $past(hit_q));

    // R8
    solo_win_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_q && !local_on(tbl_size)) |=> lwin_q);

    // R2
    lwin_block_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_q && up_local) |=> !lwin_q);

endmodule

// File: rtl/arb_latency_pipe.sv
module arb_latency_pipe
    import cascade_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  drive_slot_t din,
    input  logic [1:0]  tbl_size,
    output drive_slot_t dout
);

    drive_slot_t stg [LAT_STEPS];

    for (genvar i = 0; i < LAT_STEPS; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[i] <= '0;
            end else if (i == 0) begin
                stg[i] <= din;
            end else begin
                stg[i] <= stg[(i > 0) ? i - 1 : 0];
            end
        end
    end

    always_comb begin
        case (tbl_size)
            2'b00:   dout = stg[0];
            2'b01:   dout = stg[1];
            default: dout = stg[LAT_STEPS-1];
        endcase
    end

    // R7
    lat_shift_chk: assert property (@(posedge clk) disable iff (rst)
        $past(stg[0].win) |-> stg[1].win);

endmodule

// File: rtl/arb_win_status.sv
module arb_win_status (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    output logic status_o
);

    logic st_q;

    always_ff @(posedge clk) begin
        if (rst)        st_q <= 1'b0;
        else if (set_i) st_q <= 1'b1;
    end

    assign status_o = st_q;

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(st_q) |-> st_q);

    // R9
    status_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q) |-> $past(set_i));

endmodule

// File: rtl/cascade_winner_arbiter.sv
module cascade_winner_arbiter
    import cascade_arb_pkg::*;
#(
    parameter int DEVS_PER_BLK = 8,
    parameter int NUM_BLKS     = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    search_vld,
    input  logic                    local_hit,
    input  logic [21:0]             hit_addr,
    input  logic [DEVS_PER_BLK-2:0] lhit_in,
    input  logic [NUM_BLKS-2:0]     bhit_in,
    input  logic [1:0]              tbl_size,
    input  logic                    is_last,
    input  logic [4:0]              dev_id,
    input  logic                    cmd_vld,
    input  logic [4:0]              cmd_id,
    output logic                    lhit_out,
    output logic                    bhit_out,
    output logic                    win_status,
    output logic                    reg_sel,
    output logic                    drive_en,
    output logic [21:0]             bus_addr,
    output logic                    bus_ce_n,
    output logic                    bus_we_n,
    output logic                    bus_ale_n
);

    localparam int LOC_W = DEVS_PER_BLK - 1;
    localparam int BLK_W = NUM_BLKS - 1;
    localparam logic [ID_W-1:0] ALL_ID = '1;

    drive_slot_t resolved;
    drive_slot_t slot_out;

    arb_hit_stage #(.LOC_W(LOC_W), .BLK_W(BLK_W)) hit_i (
        .clk        (clk),
        .rst        (rst),
        .search_vld (search_vld),
        .local_hit  (local_hit),
        .hit_addr   (hit_addr),
        .lhit_in    (lhit_in),
        .bhit_in    (bhit_in),
        .tbl_size   (tbl_size),
        .lhit_q_o   (lhit_out),
        .bhit_q_o   (bhit_out),
        .slot_o     (resolved)
    );

    arb_win_status stat_i (
        .clk      (clk),
        .rst      (rst),
        .set_i    (resolved.win),
        .status_o (win_status)
    );

    arb_latency_pipe pipe_i (
        .clk      (clk),
        .rst      (rst),
        .din      (resolved),
        .tbl_size (tbl_size),
        .dout     (slot_out)
    );

    always_comb begin
        drive_en  = slot_out.win | (is_last & ~slot_out.any_hit);
        bus_addr  = slot_out.win ? slot_out.addr : '1;
        bus_ce_n  = ~slot_out.win;
        bus_ale_n = ~slot_out.win;
        bus_we_n  = 1'b1;
    end

    assign reg_sel = cmd_vld & ((cmd_id == dev_id) | (is_last & (cmd_id == ALL_ID)));

    // R4
    only_winner_drives_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_en && !is_last) |-> !bus_ce_n);

    // R6
    idle_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_en && bus_ce_n) |-> (bus_addr == '1 && bus_ale_n && bus_we_n));

    // R10
    sel_match_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && !is_last) |-> (cmd_id == dev_id && cmd_vld));

    // R5
    win_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_ce_n) |-> win_status);

endmodule

// File: tb/cascade_winner_arbiter_tb_top.sv
module cascade_winner_arbiter_tb_top;

    localparam int DPB = 8;
    localparam int NB  = 4;
    localparam int ND  = 31;
    localparam int LAT = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          srch;
    logic [ND-1:0] hit;
    logic [21:0]   haddr [ND];
    logic          cmd_vld;
    logic [4:0]    cmd_id;
    logic [1:0]    tsz_c;

    logic [ND-1:0] lho, bho, stat, sel, drv, ce, we, ale;
    logic [21:0]   baddr [ND];

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    bit chk_en = 0;

    always @(posedge clk) cnt <= cnt + 1;

    for (genvar i = 0; i < ND; i++) begin : g_dev
        localparam int B = i / DPB;
        localparam int P = i % DPB;
        logic [DPB-2:0] li;
        logic [NB-2:0]  bi;
        for (genvar j = 0; j < DPB - 1; j++) begin : g_li
            if (j < P) begin : g_on
                assign li[j] = lho[B*DPB + j];
            end else begin : g_off
                assign li[j] = 1'b0;
            end
        end
        for (genvar k = 0; k < NB - 1; k++) begin : g_bi
            if (k < B) begin : g_on
                assign bi[k] = bho[k*DPB + DPB - 1];
            end else begin : g_off
                assign bi[k] = 1'b0;
            end
        end
        cascade_winner_arbiter dut_i (
            .clk(clk), .rst(rst), .search_vld(srch), .local_hit(hit[i]),
            .hit_addr(haddr[i]), .lhit_in(li), .bhit_in(bi), .tbl_size(tsz_c),
            .is_last(i == ND - 1), .dev_id(5'(i)), .cmd_vld(cmd_vld), .cmd_id(cmd_id),
            .lhit_out(lho[i]), .bhit_out(bho[i]), .win_status(stat[i]), .reg_sel(sel[i]),
            .drive_en(drv[i]), .bus_addr(baddr[i]), .bus_ce_n(ce[i]),
            .bus_we_n(we[i]), .bus_ale_n(ale[i])
        );
    end

    // single stand-alone device for latency and masking checks
    logic        s_srch, s_hit, s_lho, s_bho, s_stat, s_sel, s_drv, s_ce, s_we, s_ale;
    logic [21:0] s_addr, s_baddr;
    logic [6:0]  s_li;
    logic [2:0]  s_bi;
    logic [1:0]  s_tsz;

    cascade_winner_arbiter dut_solo (
        .clk(clk), .rst(rst), .search_vld(s_srch), .local_hit(s_hit),
        .hit_addr(s_addr), .lhit_in(s_li), .bhit_in(s_bi), .tbl_size(s_tsz),
        .is_last(1'b0), .dev_id(5'd3), .cmd_vld(1'b0), .cmd_id(5'd0),
        .lhit_out(s_lho), .bhit_out(s_bho), .win_status(s_stat), .reg_sel(s_sel),
        .drive_en(s_drv), .bus_addr(s_baddr), .bus_ce_n(s_ce),
        .bus_we_n(s_we), .bus_ale_n(s_ale)
    );

    logic [ND-1:0] r_hit  [16];
    int            r_win  [16];
    logic [21:0]   r_addr [16];
    bit            ever_won [ND];

    function automatic int winner_of(input logic sv, input logic [ND-1:0] hv);
        if (!sv) return -1;
        for (int d = 0; d < ND; d++) if (hv[d]) return d;
        return -1;
    endfunction

    function automatic logic [ND-1:0] block_or(input logic [ND-1:0] hv);
        logic [ND-1:0] r;
        for (int d = 0; d < ND; d++) begin
            r[d] = 1'b0;
            for (int q = (d / DPB) * DPB; q <= d; q++) r[d] |= hv[q];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        int n, kd, w, nd, dsel;
        logic [21:0] ea;
        n = cnt;
        // R1
        check(lho == r_hit[n % 16], "R1", "lhit_out vector", lho, r_hit[n % 16]);
        // R2
        check(bho == block_or(r_hit[(n + 15) % 16]), "R2", "bhit_out vector",
              bho, block_or(r_hit[(n + 15) % 16]));
        kd = (n + 16 - 2 - LAT) % 16;
        w  = r_win[kd];
        ea = r_addr[kd];
        nd = $countones(drv);
        // R4
        check(nd == 1, "R4", "driver count", nd, 1);
        dsel = -1;
        for (int d = 0; d < ND; d++) if (drv[d]) dsel = d;
        if (nd == 1) begin
            if (w >= 0) begin
                // R3 R5
                check(dsel == w, "R3", "driving device", dsel, w);
                check(baddr[dsel] == ea && !ce[dsel] && !ale[dsel] && we[dsel], "R5",
                      "winner bus", {ce[dsel], we[dsel], ale[dsel], baddr[dsel]}, {3'b010, ea});
            end else begin
                // R6
                check(dsel == ND - 1, "R6", "default driver", dsel, ND - 1);
                check(baddr[dsel] == '1 && ce[dsel] && ale[dsel] && we[dsel], "R6",
                      "idle bus", {ce[dsel], we[dsel], ale[dsel], baddr[dsel]}, {3'b111, 22'h3fffff});
            end
        end
    endtask

    task automatic step(input logic sv, input logic [ND-1:0] hv,
                        input logic cv, input logic [4:0] ci);
        int idx, w;
        logic [ND-1:0] es;
        if (chk_en) check_outputs();
        srch = sv; hit = hv; cmd_vld = cv; cmd_id = ci;
        for (int d = 0; d < ND; d++) haddr[d] = 22'($urandom);
        idx = (cnt + 1) % 16;
        w = winner_of(sv, hv);
        r_hit[idx]  = sv ? hv : '0;
        r_win[idx]  = w;
        r_addr[idx] = (w >= 0) ? haddr[w] : 22'h3fffff;
        if (w >= 0 && !rst) ever_won[w] = 1'b1;
        #1;
        for (int d = 0; d < ND; d++)
            es[d] = cv && (ci == 5'(d) || (ci == 5'd31 && d == ND - 1));
        // R10
        if (chk_en) check(sel == es, "R10", "reg_sel vector", sel, es);
        @(negedge clk);
    endtask

    task automatic solo_run(input logic [1:0] tz, input logic [6:0] li,
                            input logic [2:0] bi, input int exp_edge, input string req);
        int first;
        logic [21:0] a;
        first = -1;
        a = 22'($urandom);
        s_tsz = tz; s_li = li; s_bi = bi;
        s_srch = 1'b1; s_hit = 1'b1; s_addr = a;
        @(negedge clk);
        s_srch = 1'b0; s_hit = 1'b0;
        if (s_drv) first = 1;
        for (int e = 2; e <= 8; e++) begin
            @(negedge clk);
            if (s_drv && first < 0) begin
                first = e;
                check(s_baddr == a && !s_ce, req, "solo winner bus", s_baddr, a);
            end
        end
        check(first == exp_edge, req, "solo drive edge", first, exp_edge);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cnt, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; tsz_c = 2'd2;
        srch = 0; hit = '0; cmd_vld = 0; cmd_id = 0;
        for (int d = 0; d < ND; d++) begin haddr[d] = '0; ever_won[d] = 0; end
        for (int k = 0; k < 16; k++) begin r_hit[k] = '0; r_win[k] = -1; r_addr[k] = '1; end
        s_srch = 0; s_hit = 0; s_addr = 0; s_li = 0; s_bi = 0; s_tsz = 0;
        @(negedge clk);
        repeat (3) step(1'b1, '1, 1'b0, 5'd0);
        // R11
        check(lho == '0 && bho == '0 && stat == '0, "R11", "reset flags", {lho, bho}, 0);
        check(drv == (ND)'(1) << (ND - 1), "R11", "reset driver", drv, (ND)'(1) << (ND - 1));
        check(baddr[ND-1] == '1 && ce[ND-1] && ale[ND-1], "R11", "reset idle bus",
              baddr[ND-1], 22'h3fffff);
        rst = 1'b0;

        // R7 R8 stand-alone device
        solo_run(2'd0, 7'h7f, 3'h7, 3, "R8");
        solo_run(2'd1, 7'h00, 3'h7, 4, "R7");
        solo_run(2'd1, 7'h01, 3'h0, -1, "R8");
        solo_run(2'd2, 7'h00, 3'h0, 5, "R7");
        solo_run(2'd3, 7'h00, 3'h0, 5, "R7");
        solo_run(2'd2, 7'h00, 3'h2, -1, "R3");
        // R9 lost arbitration must not set status, one win above did
        check(s_stat == 1'b1, "R9", "solo status after wins", s_stat, 1);

        repeat (8) step(1'b0, '0, 1'b0, 5'd0);
        chk_en = 1;
        // directed patterns
        step(1'b1, '1, 1'b1, 5'd31);
        step(1'b1, (ND)'(1) << 30, 1'b1, 5'd30);
        step(1'b0, '1, 1'b0, 5'd4);
        step(1'b1, ((ND)'(1) << 15) | ((ND)'(1) << 23), 1'b1, 5'd15);
        step(1'b1, ((ND)'(1) << 24) | ((ND)'(1) << 30), 1'b1, 5'd0);
        step(1'b1, '0, 1'b0, 5'd31);
        step(1'b1, (ND)'(1) << 7, 1'b1, 5'd7);
        step(1'b1, ((ND)'(1) << 9) | ((ND)'(1) << 8), 1'b1, 5'd9);
        repeat (6) step(1'b0, '0, 1'b0, 5'd0);
        // R9 status mid-run
        for (int d = 0; d < ND; d++)
            check(stat[d] == ever_won[d], "R9", $sformatf("status dev %0d", d), stat[d], ever_won[d]);

        // random sparse patterns
        for (int t = 0; t < 400; t++) begin
            logic [ND-1:0] hv;
            for (int d = 0; d < ND; d++) hv[d] = ($urandom % 14 == 0);
            step(($urandom % 5) != 0, hv, $urandom % 2 == 1, 5'($urandom));
        end
        repeat (6) step(1'b0, '0, 1'b0, 5'd0);
        for (int d = 0; d < ND; d++)
            check(stat[d] == ever_won[d], "R9", $sformatf("final status dev %0d", d), stat[d], ever_won[d]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule